// File: doc/BRIEF.md
# Rate-1/2 Convolutional Frame Transmitter with Sync Header

This block turns one parallel data word into a serial, error-protected transmit frame. A load request while idle captures the word. The block first emits a sync header made of two copies of one byte. It then walks through the captured word from bit 0 upward. Each data bit goes through a rate one-half convolutional encoder with four delay stages, which makes two coded bits per data bit.

The serial side is paced by a bit-enable input. One frame bit is produced in each cycle in which the enable is high. Each bit is shown on the output for one cycle with a valid strobe. A done strobe marks the final bit of the frame. The upper bits of the word form a zero tail, which the block forces to zero. This returns the encoder to its all-zero state at the end of every frame. A receiver can then close its trellis on a known state.

Top module: `conv_sync_tx`

## Requirements
- R1: When `busy_o` is low, a cycle with `load_i` high captures `data_i`, and `busy_o` reads high from the next cycle.
- R2: A frame has exactly 432 bits: 16 header bits, then 416 coded bits. Each bit is delivered by exactly one `ser_vld_o` pulse.
- R3: The header is the byte 11100100 sent twice. Each byte is sent from its leftmost bit, so the header order is 1,1,1,0,0,1,0,0,1,1,1,0,0,1,0,0.
- R4: Data bits enter the encoder in order from bit 0 up to bit 207. Coded pair k belongs to data bit k.
- R5: Each frame starts the encoder from the all-zero state. Take a data bit u, and let d1..d4 be the previous four data bits, with d1 the most recent. Then C1 = u^d3^d4 (generator 23 octal) and C2 = u^d1^d2^d4 (generator 35 octal). C1 is sent before C2.
- R6: Bits 200 to 207 of `data_i` are treated as zero. As a result, the last 8 serial bits of every frame are 0 and the encoder ends in the all-zero state.
- R7: Each cycle with `busy_o` and `bit_en_i` both high releases one frame bit. That bit appears on `ser_o` with `ser_vld_o` high in the following cycle. `ser_vld_o` is never high unless `bit_en_i` was high in the cycle before.
- R8: `load_i` has no effect while `busy_o` is high. The frame in progress is sent unchanged.
- R9: `done_o` is high for one cycle, together with the `ser_vld_o` of the 432nd bit. `busy_o` is low in that same cycle.
- R10: After reset, `busy_o`, `ser_vld_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Frame start request, taken only while idle |
| data_i | input | 208 | Parallel data word, bit 0 sent first |
| bit_en_i | input | 1 | Line-rate enable; one frame bit per high cycle |
| busy_o | output | 1 | A frame is in progress |
| ser_o | output | 1 | Serial frame bit |
| ser_vld_o | output | 1 | `ser_o` carries a frame bit this cycle |
| done_o | output | 1 | This cycle carries the last frame bit |

## Verification
A wrong bit counter changes the frame length. It also moves `done_o` away from the 432nd valid bit, which shows up when the frame closes. A wrong shift-register tap or a state left over from an earlier frame corrupts coded bits in the body. Against the bench's reference frame, such an error appears within a few bits of the first data bit it touches. A broken tail mask shows in the last 8 bits, and a word register that reacts to a late load changes the body right after the poke.

// File: rtl/cst_pkg.sv
package cst_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } tx_state_e;

   // number of coded bits leaving the encoder per data bit
   localparam int CODE_N = 2;

endpackage

// File: rtl/cst_frame_ctrl.sv
module cst_frame_ctrl
   import cst_pkg::*;
#(
   parameter int SYNC_W    = 8,
   parameter int SYNC_REPS = 2,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 8'b11100100,
   parameter int BODY_W    = 416,
   localparam int HDR_W    = SYNC_W * SYNC_REPS,
   localparam int FRAME_W  = HDR_W + BODY_W,
   localparam int CNT_W    = $clog2(FRAME_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic bit_en_i,
   output logic start_o,
   output logic adv_o,
   output logic last_o,
   output logic busy_o,
   output logic in_hdr_o,
   output logic phase_o,
   output logic hdr_bit_o
);

   tx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [HDR_W-1:0] hdr_q;

   assign busy_o    = (st_q == ST_SEND);
   assign start_o   = (st_q == ST_IDLE) && load_i;
   assign adv_o     = busy_o && bit_en_i;
   assign last_o    = adv_o && (cnt_q == CNT_W'(FRAME_W - 1));
   assign in_hdr_o  = (cnt_q < CNT_W'(HDR_W));
   assign phase_o   = cnt_q[0];
   assign hdr_bit_o = hdr_q[HDR_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         hdr_q <= '0;
      end else if (start_o) begin
         st_q  <= ST_SEND;
         cnt_q <= '0;
         hdr_q <= {SYNC_REPS{SYNC_PAT}};
      end else if (adv_o) begin
         hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
         if (last_o) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q < CNT_W'(FRAME_W))); // R2
   AST_START_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> (busy_o && cnt_q == '0)); // R1
   AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !bit_en_i) |=> (busy_o && $stable(cnt_q))); // R7

endmodule

// File: rtl/cst_lsb_shifter.sv
module cst_lsb_shifter #(
   parameter int DATA_W     = 208,
   parameter int TAIL_W     = 8,
   parameter bit FORCE_TAIL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              shift_i,
   input  logic              busy_i,
   output logic              bit_o
);

   logic [DATA_W-1:0] word_in;
   logic [DATA_W-1:0] word_q;

   generate
      if (FORCE_TAIL) begin : g_mask_tail
         assign word_in = {{TAIL_W{1'b0}}, data_i[DATA_W-TAIL_W-1:0]};
      end else begin : g_pass_tail
         assign word_in = data_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load_i) begin
         word_q <= word_in;
      end else if (shift_i) begin
         word_q <= {1'b0, word_q[DATA_W-1:1]};
      end
   end

   assign bit_o = word_q[0];

   AST_WORD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !shift_i) |=> $stable(word_q)); // R8

endmodule

// File: rtl/cst_conv_core.sv
module cst_conv_core
   import cst_pkg::*;
#(
   parameter int MEM               = 4,
   parameter logic [MEM:0] GEN_A   = 5'o23,
   parameter logic [MEM:0] GEN_B   = 5'o35,
   parameter bit CHECK_FLUSH       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   input  logic u_i,
   input  logic phase_i,
   input  logic end_i,
   output logic sym_o
);

   logic [MEM-1:0]    sr_q;   // sr_q[MEM-1] newest, sr_q[0] oldest
   logic [MEM:0]      win;
   logic [CODE_N-1:0] sym;

   assign win = {u_i, sr_q};

   generate
      for (genvar g = 0; g < CODE_N; g++) begin : g_tap
         localparam logic [MEM:0] TAPS = (g == 0) ? GEN_A : GEN_B;
         assign sym[g] = ^(win & TAPS);
      end
   endgenerate

   assign sym_o = sym[phase_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (clear_i) begin
         sr_q <= '0;
      end else if (step_i) begin
         sr_q <= {u_i, sr_q[MEM-1:1]};
      end
   end

   AST_FRAME_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (sr_q == '0)); // R5

   generate
      if (CHECK_FLUSH) begin : g_flush_chk
         AST_TAIL_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
            end_i |=> (sr_q == '0)); // R6
      end
   endgenerate

endmodule

// File: rtl/conv_sync_tx.sv
module conv_sync_tx
   import cst_pkg::*;
#(
   parameter int DATA_W     = 208,
   parameter int TAIL_W     = 8,
   parameter int MEM        = 4,
   parameter logic [MEM:0] GEN_A = 5'o23,
   parameter logic [MEM:0] GEN_B = 5'o35,
   parameter int SYNC_W     = 8,
   parameter int SYNC_REPS  = 2,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 8'b11100100,
   parameter bit FORCE_TAIL = 1'b1,
   localparam int BODY_W    = CODE_N * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bit_en_i,
   output logic              busy_o,
   output logic              ser_o,
   output logic              ser_vld_o,
   output logic              done_o
);

   generate
      if (MEM < 2) begin : g_bad_mem
         $error("MEM must be at least 2");
      end
      if (TAIL_W < MEM || TAIL_W >= DATA_W) begin : g_bad_tail
         $error("TAIL_W must cover MEM and be below DATA_W");
      end
      if (((SYNC_W * SYNC_REPS) % 2) != 0) begin : g_bad_hdr
         $error("header length must be even");
      end
   endgenerate

   logic start, adv, last, in_hdr, phase, hdr_bit;
   logic step, u_bit, sym;
   logic ser_q, vld_q, done_q;

   cst_frame_ctrl #(
      .SYNC_W   (SYNC_W),
      .SYNC_REPS(SYNC_REPS),
      .SYNC_PAT (SYNC_PAT),
      .BODY_W   (BODY_W)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .bit_en_i (bit_en_i),
      .start_o  (start),
      .adv_o    (adv),
      .last_o   (last),
      .busy_o   (busy_o),
      .in_hdr_o (in_hdr),
      .phase_o  (phase),
      .hdr_bit_o(hdr_bit)
   );

   assign step = adv && !in_hdr && phase;

   cst_lsb_shifter #(
      .DATA_W    (DATA_W),
      .TAIL_W    (TAIL_W),
      .FORCE_TAIL(FORCE_TAIL)
   ) shift_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .data_i (data_i),
      .shift_i(step),
      .busy_i (busy_o),
      .bit_o  (u_bit)
   );

   cst_conv_core #(
      .MEM        (MEM),
      .GEN_A      (GEN_A),
      .GEN_B      (GEN_B),
      .CHECK_FLUSH(FORCE_TAIL)
   ) core_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(start),
      .step_i (step),
      .u_i    (u_bit),
      .phase_i(phase),
      .end_i  (last),
      .sym_o  (sym)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_q  <= 1'b0;
         vld_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         vld_q  <= adv;
         done_q <= last;
         if (adv) begin
            ser_q <= in_hdr ? hdr_bit : sym;
         end
      end
   end

   assign ser_o     = ser_q;
   assign ser_vld_o = vld_q;
   assign done_o    = done_q;

   AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ser_vld_o); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R9
   AST_VLD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ser_vld_o |-> $past(bit_en_i)); // R7

endmodule

// File: tb/conv_sync_tx_tb.sv
`timescale 1ns/1ps
module conv_sync_tx_tb_top;

   localparam int DW = 208;
   localparam int FW = 432;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [DW-1:0] data_i = '0;
   logic          bit_en_i = 1'b0;
   logic          busy_o, ser_o, ser_vld_o, done_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [FW-1:0] got;
   int nb, done_cnt, done_pos, cyc, first_v, last_v;

   always #2.5 clk = ~clk;

   conv_sync_tx dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
      .bit_en_i(bit_en_i), .busy_o(busy_o), .ser_o(ser_o),
      .ser_vld_o(ser_vld_o), .done_o(done_o)
   );

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n && ser_vld_o) begin
         if (nb < FW) got[nb] = ser_o;
         if (nb == 0) first_v = cyc;
         last_v = cyc;
         nb = nb + 1;
         if (done_o) begin
            done_cnt = done_cnt + 1;
            done_pos = nb;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] model(input logic [DW-1:0] d);
      logic [FW-1:0] f;
      logic [3:0]    s;   // s[3]=d1 ... s[0]=d4
      logic [DW-1:0] m;
      logic [7:0]    pat;
      logic          u;
      pat = 8'b11100100;
      m = d;
      m[DW-1:DW-8] = '0;
      f = '0;
      s = '0;
      for (int n = 0; n < 16; n++) f[n] = pat[7 - (n % 8)];
      for (int i = 0; i < DW; i++) begin
         u = m[i];
         f[16 + 2*i]     = u ^ s[1] ^ s[0];
         f[16 + 2*i + 1] = u ^ s[3] ^ s[2] ^ s[0];
         s = {u, s[3:1]};
      end
      return f;
   endfunction

   function automatic logic [DW-1:0] rnd_word();
      logic [223:0] t;
      for (int k = 0; k < 7; k++) t[k*32 +: 32] = $urandom();
      return t[DW-1:0];
   endfunction

   function automatic int first_diff(input logic [FW-1:0] a, input logic [FW-1:0] b);
      for (int k = 0; k < FW; k++) if (a[k] !== b[k]) return k;
      return -1;
   endfunction

   // mode 0: enable always high, 1: random, 2: every third cycle, 3: 30-cycle stall first
   task automatic run_frame(input logic [DW-1:0] d, input int mode, input bit poke);
      logic [FW-1:0] exp;
      int            c;
      bit            fin;
      exp = model(d);
      @(negedge clk);
      nb = 0; done_cnt = 0; done_pos = -1; first_v = 0; last_v = 0;
      data_i = d; load_i = 1'b1; bit_en_i = 1'b0;
      @(negedge clk);
      load_i = 1'b0;
      data_i = rnd_word();
      chk(busy_o == 1'b1, "R1 busy after load", busy_o, 1);
      fin = 0;
      for (c = 0; c < 6000; c++) begin
         @(negedge clk);
         if (done_cnt != 0) begin fin = 1; break; end
         case (mode)
            0: bit_en_i = 1'b1;
            1: bit_en_i = 1'($urandom() & 1);
            2: bit_en_i = ((c % 3) == 0);
            default: bit_en_i = (c >= 30);
         endcase
         if (mode == 3 && c == 29)
            chk(nb == 0 && busy_o, "R7 no bit while enable low", nb, 0);
         if (poke && (c == 40 || c == 41)) begin
            load_i = 1'b1;
            data_i = ~d;
         end else begin
            load_i = 1'b0;
         end
      end
      bit_en_i = 1'b0;
      load_i = 1'b0;
      chk(fin, "R9 frame finished before timeout", fin, 1);
      @(negedge clk);
      chk(nb == FW, "R2 bits per frame", nb, FW);
      chk(done_cnt == 1 && done_pos == FW, "R9 done on last bit", done_pos, FW);
      chk(busy_o == 1'b0, "R9 idle after done", busy_o, 0);
      chk(got[15:0] == exp[15:0], "R3 header", got[15:0], exp[15:0]);
      chk(got[16] == d[0] && got[17] == d[0], "R4 first pair from bit 0", got[17:16], {d[0], d[0]});
      chk(got == exp, poke ? "R8 frame unchanged by load" : "R5 coded body",
          first_diff(got, exp), -1);
      chk(got[FW-1:FW-8] == 8'h00, "R6 zero tail bits", got[FW-1:FW-8], 0);
      if (mode == 0)
         chk(last_v - first_v == FW - 1, "R7 one bit per enabled cycle", last_v - first_v, FW - 1);
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] alt;
      cyc = 0; nb = 0; done_cnt = 0; done_pos = -1;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(!busy_o && !ser_vld_o && !done_o, "R10 reset outputs",
          {busy_o, ser_vld_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !ser_vld_o && !done_o, "R10 idle after reset",
          {busy_o, ser_vld_o, done_o}, 0);

      // directed corners
      run_frame('0, 0, 1'b0);
      run_frame('1, 0, 1'b0);          // R6: tail bits set in the input
      for (int k = 0; k < DW; k++) alt[k] = k[0];
      run_frame(alt, 2, 1'b0);
      run_frame(rnd_word(), 3, 1'b0);  // R7 stall
      run_frame(rnd_word(), 0, 1'b1);  // R8 load while busy
      run_frame(rnd_word(), 1, 1'b1);  // R8 load while busy, random pacing

      // random frames, back to back
      for (int k = 0; k < 6; k++) run_frame(rnd_word(), k % 3, 1'b0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule